// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device and decides when a program or erase operation has finished. The device signals progress through a toggle bit that changes between successive status reads while its internal algorithm runs, and through a timeout bit that goes high when the algorithm has exceeded its internal limit. After a one-cycle start pulse, the poller reads status bytes through a request/acknowledge read port and compares the toggle bit of each new read with the previous one. It then finishes with pass, fail or a watchdog result.

When the timeout bit is seen while the toggle bit is still changing, the poller does not fail at once. It takes a fresh pair of reads, because toggling may have stopped in the same read that raised the timeout bit. On fail or watchdog it sends the array-read reset command through a write port before it reports completion. A pause input lets the system leave polling. Every new start begins again with the initial pair of reads.

The asynchronous active-low reset is released synchronously inside the block, two clock edges after the reset pin rises.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, rd_req_o and wr_req_o are all 0.
- R2: After a start pulse the block makes two reads. If the toggle bit (bit 6 of the status byte, set by parameter TOGGLE_BIT) is equal in both, done_o pulses with result_o = 2'b00 (pass) after exactly two reads and no write.
- R3: When the toggle bit changed and the timeout bit (bit 5) of the newest read is 0, polling continues. Each new read is compared with the read before it, and the first equal pair ends the run as pass.
- R4: When the toggle bit changed and bit 5 of the newest read is 1, exactly two more reads are made. If their toggle bits are equal, the result is pass with no write.
- R5: If the toggle bit still differs in that re-check pair, the result is 2'b01 (fail). Exactly one write of 8'hF0 is made first, and done_o pulses only after that write is acknowledged.
- R6: If MAX_POLLS reads have completed in the comparison phase, the latest pair still differs and bit 5 is 0, the result is 2'b10 (watchdog). One write of 8'hF0 precedes done_o.
- R7: If pause_i is high when a read is acknowledged, the block returns to idle with no done_o and no write. The next start begins again with a fresh initial pair of reads.
- R8: A start pulse while busy_o is high has no effect on the run in progress.
- R9: rd_req_o and wr_req_o are never high together, and each request stays high until it is acknowledged.
- R10: Status bits other than the toggle bit and bit 5 have no effect on the result or on the number of reads.
- R11: done_o is a single-cycle pulse, and busy_o is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a polling run |
| pause_i | input | 1 | Leave polling at the next read acknowledge |
| rd_req_o | output | 1 | Status read request, held until acknowledged |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid with it |
| rd_data_i | input | 8 | Status byte returned by the device |
| wr_req_o | output | 1 | Reset-command write request, held until acknowledged |
| wr_data_o | output | 8 | Command byte (8'hF0) |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 pass, 01 fail, 10 watchdog; valid with done_o |

## Verification
The assertions assume that rd_ack_i and wr_ack_i come only while the matching request is high, and that each acknowledge lasts one cycle. They also assume that pause_i is raised only while a run is in progress. The bench's device responder acknowledges requests only after it has seen them, drops each acknowledge on the next cycle, and waits a random gap of zero to three cycles between reads. Each status byte carries random values in every bit other than the toggle and timeout bits. Start pulses and pause are driven only at points where these assumptions still hold.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FIRST = 3'd1,
    ST_POLL  = 3'd2,
    ST_RCK_A = 3'd3,
    ST_RCK_B = 3'd4,
    ST_CMD   = 3'd5,
    ST_FIN   = 3'd6
  } fdp_state_e;

  typedef enum logic [1:0] {
    RES_PASS = 2'b00,
    RES_FAIL = 2'b01,
    RES_WDOG = 2'b10
  } fdp_result_e;
endpackage

// File: rtl/fdp_bit_track.sv
module fdp_bit_track #(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int TMO_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              changed,
  output logic              tmo_seen
);
  logic prev_q;
  logic prev_d;
  logic tog_now;

  generate
    if (TOGGLE_BIT == TMO_BIT) begin : g_bad_cfg
      // a shared bit position would make every timeout look like a toggle
      assign tog_now = 1'b0;
    end else begin : g_cfg
      assign tog_now = rd_data[TOGGLE_BIT];
    end
  endgenerate

  always_comb begin
    prev_d = prev_q;
    if (cap_en) prev_d = tog_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign changed  = tog_now ^ prev_q;
  assign tmo_seen = rd_data[TMO_BIT];
endmodule

// File: rtl/fdp_poll_budget.sv
module fdp_poll_budget #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the read now completing is number MAX_POLLS
  assign last = (cnt_q == CW'(MAX_POLLS - 1));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_POLLS))
    else $error("read budget exceeded");
endmodule

// File: rtl/fdp_ctrl.sv
module fdp_ctrl
  import fdp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pause,
  input  logic        rd_ack,
  input  logic        wr_ack,
  input  logic        changed,
  input  logic        tmo_seen,
  input  logic        last,
  output logic        rd_req,
  output logic        wr_req,
  output logic        cap_en,
  output logic        cnt_clr,
  output logic        cnt_inc,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result
);
  fdp_state_e  st_q, st_d;
  fdp_result_e res_q, res_d;

  always_comb begin
    st_d    = st_q;
    res_d   = res_q;
    cap_en  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        cnt_clr = 1'b1;
        st_d    = ST_FIRST;
      end
      ST_FIRST: if (rd_ack) begin
        cap_en  = 1'b1;
        cnt_inc = 1'b1;
        st_d    = pause ? ST_IDLE : ST_POLL;
      end
      ST_POLL: if (rd_ack) begin
        cap_en  = 1'b1;
        cnt_inc = 1'b1;
        if (pause)         st_d = ST_IDLE;
        else if (!changed) begin res_d = RES_PASS; st_d = ST_FIN; end
        else if (tmo_seen) st_d = ST_RCK_A;
        else if (last)     begin res_d = RES_WDOG; st_d = ST_CMD; end
      end
      ST_RCK_A: if (rd_ack) begin
        cap_en = 1'b1;
        st_d   = pause ? ST_IDLE : ST_RCK_B;
      end
      ST_RCK_B: if (rd_ack) begin
        cap_en = 1'b1;
        if (pause)         st_d = ST_IDLE;
        else if (!changed) begin res_d = RES_PASS; st_d = ST_FIN; end
        else               begin res_d = RES_FAIL; st_d = ST_CMD; end
      end
      ST_CMD: if (wr_ack) st_d = ST_FIN;
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      res_q <= RES_PASS;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  assign rd_req = (st_q == ST_FIRST) || (st_q == ST_POLL) ||
                  (st_q == ST_RCK_A) || (st_q == ST_RCK_B);
  assign wr_req = (st_q == ST_CMD);
  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_FIN);
  assign result = res_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req && !done))
    else $error("idle with activity");
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req))
    else $error("read and write together");
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req)
    else $error("read request dropped");
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req)
    else $error("write request dropped");
  p_fail_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result != RES_PASS)) |-> $past(wr_req && wr_ack))
    else $error("failure reported before reset write");
  p_pass_no_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result == RES_PASS)) |-> $past(rd_req && rd_ack))
    else $error("pass not directly after a read");
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy))
    else $error("done longer than a cycle");
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int          DATA_W     = 8,
  parameter int          TOGGLE_BIT = 6,
  parameter int          TMO_BIT    = 5,
  parameter int          MAX_POLLS  = 64,
  parameter logic [7:0]  RESET_CMD  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pause_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cap_en, cnt_clr, cnt_inc, changed, tmo_seen, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fdp_bit_track #(
    .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .TMO_BIT(TMO_BIT)
  ) u_track (
    .clk(clk), .rst_n(rst_int_n), .cap_en(cap_en), .rd_data(rd_data_i),
    .changed(changed), .tmo_seen(tmo_seen)
  );

  fdp_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk(clk), .rst_n(rst_int_n), .clr(cnt_clr), .inc(cnt_inc), .last(last)
  );

  fdp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start_i), .pause(pause_i),
    .rd_ack(rd_ack_i), .wr_ack(wr_ack_i), .changed(changed),
    .tmo_seen(tmo_seen), .last(last), .rd_req(rd_req_o), .wr_req(wr_req_o),
    .cap_en(cap_en), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .busy(busy_o),
    .done(done_o), .result(result_o)
  );

  assign wr_data_o = DATA_W'(RESET_CMD);
endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
  localparam int MAXP = 16;

  logic clk, rst_n, start_i, pause_i, rd_ack_i, wr_ack_i;
  logic [7:0] rd_data_i, wr_data_o;
  logic rd_req_o, wr_req_o, busy_o, done_o;
  logic [1:0] result_o;

  int total, bad;
  int settle, tmo, dev_idx, rd_cnt, wr_cnt, done_cnt, clash, gap;
  logic [7:0] wr_seen;

  flash_done_poller #(.MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pause_i(pause_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary_and_end();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary_and_end();
  end

  // status byte of the modelled device: toggle bit on bit 6, timeout bit on bit 5
  function automatic logic [7:0] dev_byte(int i);
    logic [7:0] b;
    b = 8'($urandom);
    b[6] = (i < settle) ? i[0] : settle[0];
    b[5] = (i >= tmo);
    return b;
  endfunction

  // expected result, reads, writes from the requirements
  task automatic predict(input int s, input int t, output int res, output int nr, output int nw);
    int k;
    k = 1;
    forever begin
      if (k - 1 >= s) begin res = 0; nr = k + 1; nw = 0; return; end
      if (k >= t) begin
        nr = k + 3;
        if (k + 1 >= s) begin res = 0; nw = 0; end
        else begin res = 1; nw = 1; end
        return;
      end
      if (k + 1 >= MAXP) begin res = 2; nr = k + 1; nw = 1; return; end
      k++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack_i = 1'b0; wr_ack_i = 1'b0; gap = 0;
    end else begin
      if (rd_ack_i) rd_ack_i = 1'b0;
      else if (rd_req_o) begin
        if (gap == 0) begin
          rd_ack_i = 1'b1; rd_data_i = dev_byte(dev_idx);
          dev_idx++; rd_cnt++; gap = $urandom_range(0, 3);
        end else gap--;
      end
      if (wr_ack_i) wr_ack_i = 1'b0;
      else if (wr_req_o) begin
        wr_ack_i = 1'b1; wr_cnt++; wr_seen = wr_data_o;
      end
    end
  end

  always @(posedge clk) begin
    if (done_o) done_cnt++;
    if (rd_req_o && wr_req_o) clash++;
  end

  task automatic run_case(input int s, input int t, input bit poke, input string tag);
    int er, enr, enw, got, inj;
    logic [1:0] res;
    settle = s; tmo = t; dev_idx = 0; rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    got = 0; res = 2'b11;
    predict(s, t, er, enr, enw);
    inj = poke ? $urandom_range(2, 8) : -1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int j = 0; j < 2000 && got == 0; j++) begin
      if (j == inj && busy_o) start_i = 1'b1;
      else start_i = 1'b0;
      if (done_o) begin got = 1; res = result_o; end
      else @(negedge clk);
    end
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(got == 1, {tag, " done seen"}, got, 1);
    chk(res == 2'(er), {tag, " result"}, int'(res), er);
    chk(rd_cnt == enr, {tag, " reads"}, rd_cnt, enr);
    chk(wr_cnt == enw, {tag, " writes"}, wr_cnt, enw);
    if (enw != 0) chk(wr_seen == 8'hF0, {tag, " R5 command byte"}, int'(wr_seen), 240);
    chk(done_cnt == 1 && !busy_o, {tag, " R11 single done then idle"}, done_cnt, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    total = 0; bad = 0; clash = 0;
    start_i = 1'b0; pause_i = 1'b0; rd_data_i = 8'h00;
    settle = 0; tmo = 1000; dev_idx = 0; rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !rd_req_o && !wr_req_o, "R1 reset idle", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_req_o && !wr_req_o, "R1 idle after release", int'(rd_req_o), 0);

    run_case(0, 1000, 0, "R2 settled at once");
    run_case(3, 1000, 0, "R3 settles after polling");
    run_case(2, 1, 0, "R4 race recheck passes");
    run_case(1000, 1, 0, "R5 still toggling fails");
    run_case(1000, 1000, 0, "R6 watchdog");
    run_case(7, 5, 1, "R8 start while busy");

    // R7: leave polling, then restart from a fresh pair
    settle = 1000; tmo = 1000; dev_idx = 0; rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int j = 0; j < 200 && rd_cnt < 3; j++) @(negedge clk);
    pause_i = 1'b1;
    for (int j = 0; j < 200 && busy_o; j++) @(negedge clk);
    pause_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy_o, "R7 idle after pause", int'(busy_o), 0);
    chk(done_cnt == 0 && wr_cnt == 0, "R7 no done or write on pause", done_cnt + wr_cnt, 0);
    run_case(0, 1000, 0, "R7 restart needs two reads");

    // R10 and general: random device behaviour, random other status bits
    for (int n = 0; n < 40; n++) begin
      int s, t;
      s = ($urandom_range(0, 4) == 0) ? 1000 : $urandom_range(0, 20);
      t = ($urandom_range(0, 2) == 0) ? 1000 : $urandom_range(1, 24);
      run_case(s, t, n[0], "R10 random");
    end

    chk(clash == 0, "R9 read and write never together", clash, 0);
    summary_and_end();
  end
endmodule